// File: doc/BRIEF.md
# Four-Channel Volume Register Slave with Serial Write Port

This block is the control front end of a four-channel electronic volume controller. It watches a two-wire serial bus (I2C) through a fast system clock, recognises its own write address, and keeps five 8-bit control registers. Four of them carry one volume code per channel. The fifth drives two general-purpose logic outputs. Each channel also has a mute flag, derived from its code.

A host writes a frame made of four parts: START, the device address, a register pointer, then any number of data bytes, closed by STOP. After each data byte is stored, the pointer moves to the next register. After the last register it returns to the first, so the host can update the whole bank in one burst. The low bit of the device address comes from a strap input, so two copies can share one bus. The slave never answers reads and never stretches the clock.

Top module: `i2c_volreg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose top seven bits are 1000_00s, with s equal to `addr_strap`, and whose last bit (R/W) is 0. This gives 80h with the strap low and 82h with the strap high. To acknowledge, it asserts `sda_pull` from the SCL fall after the eighth bit until the SCL fall that ends the ninth clock.
- R2: An address byte that does not match, or that has R/W = 1, gets no acknowledge. Every later byte of that frame gets no acknowledge and changes no register.
- R3: In an addressed frame, the pointer byte and every data byte are acknowledged. Each data byte is stored in the register the pointer selects.
- R4: After each stored data byte, the pointer steps 00h, 01h, 02h, 03h, 04h and then wraps back to 00h.
- R5: Registers 00h to 03h are the codes of channels 1 to 4, presented on `vol_codes[8*i+7:8*i]` for channel i+1. Code FFh means 0 dB, and each lower code attenuates by a further 0.5 dB.
- R6: In register 04h, data bit 0 drives `aux[0]` and data bit 1 drives `aux[1]`, with 1 giving a high level. Bits 7 to 2 have no effect.
- R7: Reset clears all five registers. The reset state is `vol_codes` = 0, `aux` = 0, `mute` all ones and `sda_pull` low.
- R8: `mute[i]` is high exactly when the code of channel i+1 is below 37h. Code 37h (-100 dB) is not muted, and code 00h is muted.
- R9: A pointer byte above 04h is still acknowledged. The data bytes that follow it are acknowledged but discarded until a new frame loads a valid pointer.
- R10: A STOP or a repeated START at any point ends the current frame and drops any partial byte. A repeated START begins a new address phase.
- R11: After the two-flop synchronisers, SCL and SDA change their filtered level only after FILT_LEN equal samples in a row. A one-clock pulse on SCL is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus (wired-AND level) |
| addr_strap | input | 1 | Selects the address bit that tells 80h and 82h apart |
| sda_pull | output | 1 | High to pull SDA low for an acknowledge |
| vol_codes | output | NUM_VOL*8 | Volume codes, channel 1 in the low byte |
| mute | output | NUM_VOL | Mute flag for each channel |
| aux | output | 2 | General-purpose logic outputs |

## Verification
The bench builds the slave with its default parameters: four channels, so the pointer wraps after 04h, and a three-sample filter. With these values a burst of five data bytes sweeps every register and crosses the wrap point. A single-clock SCL pulse falls below the filter threshold and can show whether the filter rejects it. The sample rate is 63 system clocks per quarter SCL period. This leaves room for the synchroniser and filter delay, both at the SCL edges where data is sampled and at the edges where the acknowledge is released.

// File: rtl/i2c_volreg_slave.sv
module i2c_volreg_slave #(
  parameter int          NUM_VOL    = 4,
  parameter int          FILT_LEN   = 3,
  parameter logic [5:0]  ADDR_HI    = 6'b100000,
  parameter logic [7:0]  MUTE_BELOW = 8'h37
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  input  logic                 addr_strap,
  output logic                 sda_pull,
  output logic [NUM_VOL*8-1:0] vol_codes,
  output logic [NUM_VOL-1:0]   mute,
  output logic [1:0]           aux
);
  localparam int              PTR_W    = $clog2(NUM_VOL + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_VOL);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK, S_SKIP} state_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  logic [1:0]          scl_sync, sda_sync;
  logic [FILT_LEN-1:0] scl_hist, sda_hist;
  logic                scl_f, sda_f, scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_hist <= '1;
      sda_hist <= '1;
      scl_f    <= 1'b1;
      sda_f    <= 1'b1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_hist <= {scl_hist[FILT_LEN-2:0], scl_sync[1]};
      sda_hist <= {sda_hist[FILT_LEN-2:0], sda_sync[1]};
      if (&scl_hist)       scl_f <= 1'b1;
      else if (~|scl_hist) scl_f <= 1'b0;
      if (&sda_hist)       sda_f <= 1'b1;
      else if (~|sda_hist) sda_f <= 1'b0;
      scl_prev <= scl_f;
      sda_prev <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_f & ~scl_prev;
  assign scl_fall = ~scl_f & scl_prev;
  assign start_ev = scl_f & scl_prev & sda_prev & ~sda_f;
  assign stop_ev  = scl_f & scl_prev & ~sda_prev & sda_f;

  state_t           state;
  kind_t            kind;
  logic [3:0]       bitcnt;
  logic [7:0]       sh;
  logic [PTR_W-1:0] ptr;
  logic             ptr_ok;
  logic             byte_done, data_wr, addr_hit;

  assign byte_done = (state == S_RX) && scl_fall && (bitcnt == 4'd8);
  assign data_wr   = byte_done && (kind == K_DATA) && ptr_ok;
  assign addr_hit  = (sh[7:1] == {ADDR_HI, addr_strap}) && !sh[0];
  assign sda_pull  = (state == S_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind   <= K_ADDR;
      bitcnt <= '0;
      sh     <= '0;
      ptr    <= '0;
      ptr_ok <= 1'b0;
    end else if (start_ev) begin
      state  <= S_RX;
      kind   <= K_ADDR;
      bitcnt <= '0;
      ptr_ok <= 1'b0;
    end else if (stop_ev) begin
      state  <= S_IDLE;
      ptr_ok <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            sh     <= {sh[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            case (kind)
              K_ADDR: state <= addr_hit ? S_ACK : S_SKIP;
              K_PTR: begin
                ptr    <= sh[PTR_W-1:0];
                ptr_ok <= (sh <= 8'(NUM_VOL));
                state  <= S_ACK;
              end
              default: begin
                if (ptr_ok) ptr <= (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
                state <= S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            state  <= S_RX;
            bitcnt <= '0;
            case (kind)
              K_ADDR:  kind <= K_PTR;
              default: kind <= K_DATA;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_VOL; i++) begin : g_ch
    logic [7:0] code_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   code_q <= '0;
      else if (data_wr && ptr == PTR_W'(i))         code_q <= sh;
    end
    assign vol_codes[i*8 +: 8] = code_q;
    assign mute[i]             = (code_q < MUTE_BELOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          aux <= '0;
    else if (data_wr && ptr == LAST_PTR) aux <= sh[1:0];
  end
endmodule

// File: rtl/i2c_volreg_slave_chk.sv
module i2c_volreg_slave_chk #(
  parameter int NUM_VOL = 4,
  parameter int PTR_W   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scl_f,
  input logic                 stop_ev,
  input logic                 sda_pull,
  input logic [NUM_VOL*8-1:0] vol_codes,
  input logic [NUM_VOL-1:0]   mute,
  input logic [1:0]           aux,
  input logic [PTR_W-1:0]     ptr,
  input logic                 ptr_ok
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (vol_codes == '0 && aux == 2'b00 && !sda_pull)); // R7
  AST_ACK_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n) past_ok && $rose(sda_pull) |-> !scl_f); // R1
  AST_CODE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n) past_ok && !$stable(vol_codes) |-> $rose(sda_pull)); // R3
  AST_AUX_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n) past_ok && !$stable(aux) |-> $rose(sda_pull)); // R6
  AST_MUTE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) past_ok && !$stable(mute) |-> !$stable(vol_codes)); // R8
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ptr_ok |-> ptr <= PTR_W'(NUM_VOL)); // R4
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) stop_ev |=> !sda_pull); // R10
endmodule

bind i2c_volreg_slave i2c_volreg_slave_chk #(.NUM_VOL(NUM_VOL), .PTR_W(PTR_W)) chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .stop_ev(stop_ev), .sda_pull(sda_pull),
  .vol_codes(vol_codes), .mute(mute), .aux(aux), .ptr(ptr), .ptr_ok(ptr_ok)
);

// File: tb/i2c_volreg_slave_test.sv
module i2c_volreg_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 63;

  logic        clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, strap = 1'b0;
  logic        sda_pull, sda_line;
  logic [31:0] vol_codes;
  logic [3:0]  mute;
  logic [1:0]  aux;
  int          errors = 0, checks = 0;

  logic [7:0]  exp_vol [4];
  logic [1:0]  exp_aux;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  i2c_volreg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .addr_strap(strap),
    .sda_pull(sda_pull), .vol_codes(vol_codes), .mute(mute), .aux(aux)
  );

  localparam logic [24:0] VEC [8] = '{
    {1'b0, 8'h80, 8'h00, 8'hFF},
    {1'b0, 8'h80, 8'h03, 8'h37},
    {1'b0, 8'h80, 8'h02, 8'h36},
    {1'b0, 8'h82, 8'h01, 8'h55},
    {1'b1, 8'h82, 8'h01, 8'h55},
    {1'b1, 8'h80, 8'h00, 8'h11},
    {1'b0, 8'h80, 8'h04, 8'hFE},
    {1'b0, 8'h81, 8'h00, 8'h22}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] ev;
    logic [3:0]  em;
    ev = {exp_vol[3], exp_vol[2], exp_vol[1], exp_vol[0]};
    for (int i = 0; i < 4; i++) em[i] = (exp_vol[i] < 8'h37);
    checks += 3;
    if (vol_codes !== ev) begin
      errors++;
      $display("FAIL %s R5 codes: got %h expected %h", tag, vol_codes, ev);
    end
    if (aux !== exp_aux) begin
      errors++;
      $display("FAIL %s R6 aux: got %b expected %b", tag, aux, exp_aux);
    end
    if (mute !== em) begin
      errors++;
      $display("FAIL %s R8 mute: got %b expected %b", tag, mute, em);
    end
  endtask

  function automatic logic [2:0] model_write(input logic [2:0] p, input logic [7:0] d);
    if (p == 3'd4) exp_aux = d[1:0];
    else           exp_vol[p[1:0]] = d;
    return (p == 3'd4) ? 3'd0 : p + 3'd1;
  endfunction

  task automatic bus_start;
    wait_clk(QTR); m_sda = 1'b1;
    wait_clk(QTR); m_scl = 1'b1;
    wait_clk(QTR); m_sda = 1'b0;
    wait_clk(QTR); m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    wait_clk(QTR); m_sda = 1'b0;
    wait_clk(QTR); m_scl = 1'b1;
    wait_clk(QTR); m_sda = 1'b1;
    wait_clk(2*QTR);
  endtask

  task automatic bit_out(input logic b, input logic glitch);
    wait_clk(QTR); m_sda = b;
    if (glitch) begin
      wait_clk(QTR/2); m_scl = 1'b1;
      wait_clk(1);     m_scl = 1'b0;
      wait_clk(QTR - QTR/2 - 1);
    end else wait_clk(QTR);
    m_scl = 1'b1;
    wait_clk(2*QTR);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input int glitch_bit, output logic acked);
    for (int i = 7; i >= 0; i--) bit_out(d[i], glitch_bit == i);
    wait_clk(QTR); m_sda = 1'b1;
    wait_clk(QTR); m_scl = 1'b1;
    wait_clk(QTR); acked = (sda_line === 1'b0);
    wait_clk(QTR); m_scl = 1'b0;
  endtask

  task automatic frame3(input logic [7:0] a, input logic [7:0] p, input logic [7:0] d, input string tag);
    logic hit, k0, k1, k2;
    logic [2:0] np;
    hit = (a[7:1] == {6'b100000, strap}) && !a[0];
    bus_start;
    send_byte(a, -1, k0);
    send_byte(p, -1, k1);
    send_byte(d, -1, k2);
    bus_stop;
    check_bit({tag, " R1/R2 address ack"}, k0, hit);
    check_bit({tag, " R3/R2 pointer ack"}, k1, hit);
    check_bit({tag, " R3/R2 data ack"}, k2, hit);
    if (hit && p <= 8'h04) np = model_write(p[2:0], d);
    check_regs(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic k;
    logic [2:0] p;
    for (int i = 0; i < 4; i++) exp_vol[i] = 8'h00;
    exp_aux = 2'b00;
    wait_clk(5);
    check_bit("R7 reset sda_pull", sda_pull, 1'b0);
    check_regs("R7 reset");
    rst_n = 1'b1;
    wait_clk(5);

    for (int v = 0; v < 8; v++) begin
      strap = VEC[v][24];
      frame3(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], $sformatf("vec%0d", v));
    end

    // R4: burst across the wrap point
    strap = 1'b0;
    bus_start;
    send_byte(8'h80, -1, k);
    send_byte(8'h03, -1, k);
    p = 3'd3;
    for (int i = 0; i < 5; i++) begin
      send_byte(8'hA0 + 8'(i), -1, k);
      check_bit("R4 burst data ack", k, 1'b1);
      p = model_write(p, 8'hA0 + 8'(i));
    end
    bus_stop;
    check_regs("R4 wrap burst");

    // R9: out-of-range pointer
    bus_start;
    send_byte(8'h80, -1, k);
    send_byte(8'h07, -1, k);
    check_bit("R9 bad pointer ack", k, 1'b1);
    send_byte(8'h5A, -1, k);
    check_bit("R9 discarded data ack", k, 1'b1);
    send_byte(8'h5B, -1, k);
    bus_stop;
    check_regs("R9 discarded");

    // R10: partial byte cut by STOP
    bus_start;
    send_byte(8'h80, -1, k);
    send_byte(8'h01, -1, k);
    for (int i = 7; i >= 4; i--) bit_out(1'b1, 1'b0);
    bus_stop;
    check_regs("R10 stop abort");

    // R10: repeated START mid-frame
    bus_start;
    send_byte(8'h80, -1, k);
    send_byte(8'h02, -1, k);
    for (int i = 7; i >= 5; i--) bit_out(1'b0, 1'b0);
    bus_start;
    send_byte(8'h80, -1, k);
    check_bit("R10 restart address ack", k, 1'b1);
    send_byte(8'h00, -1, k);
    send_byte(8'h77, -1, k);
    bus_stop;
    p = model_write(3'd0, 8'h77);
    check_regs("R10 repeated start");

    // R11: one-clock SCL pulse inside a data byte
    bus_start;
    send_byte(8'h80, -1, k);
    send_byte(8'h01, -1, k);
    send_byte(8'hC3, 3, k);
    check_bit("R11 glitch data ack", k, 1'b1);
    bus_stop;
    p = model_write(3'd1, 8'hC3);
    check_regs("R11 glitch");

    // R7: reset after traffic
    rst_n = 1'b0;
    wait_clk(3);
    for (int i = 0; i < 4; i++) exp_vol[i] = 8'h00;
    exp_aux = 2'b00;
    check_regs("R7 late reset");
    check_bit("R7 late reset sda_pull", sda_pull, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule